// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block sits on the host side of a paged serial flash. It drives the chip over a mode-0 SPI link. A single request names one of six program or erase operations, a buffer selector and an 11-bit page number. The block then sends a four-byte command frame and raises chip select, which starts the flash's self-timed operation. After a short high gap it lowers chip select again, sends the status opcode and keeps clocking status bytes in the same frame until bit 7 reads 1. It then pulses `done`, and raises `err` with that pulse if the programmable poll limit ran out first.

The controller has six states. `S_IDLE` accepts a request with a legal operation code and moves to `S_CMD`. `S_CMD` shifts the four command bytes and moves to `S_GAP` after the fourth byte. `S_GAP` holds chip select high for `GAP_CLKS` clocks and then moves to `S_POLL_OP`. `S_POLL_OP` shifts the status opcode and moves to `S_POLL_RD`. `S_POLL_RD` clocks status bytes. It moves to `S_DONE` either on a ready byte or on a not-ready byte once the limit is used up. `S_DONE` lasts one cycle and returns to `S_IDLE`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `err` are 0.
- R2: The first byte of the command frame depends on `req_op`. For `req_op`=0 it is 83h, or 86h when `req_buf`=1. For 1 it is 88h, or 89h when `req_buf`=1. For 2 it is 81h, for 3 it is 50h and for 4 it is 7Ch. The frame holds exactly four bytes.
- R3: For operations 0, 1 and 2 the three address bytes carry, MSB first, four zero bits, the 11-bit page number, then nine zero bits.
- R4: Block erase (3) sends four zero bits, page bits 10..3 and twelve zero bits. Sector erase (4) sends four zero bits, page bits 10..8 and seventeen zero bits.
- R5: Chip erase (`req_op`=5) sends C7h 94h 80h 9Ah whatever the values of `req_page` and `req_buf`.
- R6: Chip select rises at the end of the command frame and stays high for at least two system clocks (`GAP_CLKS`) before the status frame starts.
- R7: The status frame starts with 57h and then reads status bytes back to back until one has bit 7 set. The other bits are ignored. `done` is then high for exactly one cycle with `err` at 0.
- R8: With limit N = `poll_limit`, where 0 counts as 1, at most N status bytes are read. If none of them is ready, the frame ends and `done` comes with `err`=1. A ready Nth byte still counts as success.
- R9: `busy` is high from the cycle after acceptance up to and including the `done` cycle. Requests seen while `busy` is high are ignored.
- R10: Operation codes 6 and 7 are ignored: there is no chip-select activity, no `busy` and no `done`.
- R11: SPI mode 0: SCK is low whenever chip select is high, and every byte is sent MSB first, with the flash sampling MOSI and the block sampling MISO on SCK rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code, 0..5 legal |
| req_buf | input | 1 | Buffer selector for program operations |
| req_page | input | 11 | Page number |
| poll_limit | input | LIMIT_W | Maximum status bytes read (0 counts as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit exhausted, valid with done |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The ready check and the limit check are evaluated on the same status byte, so the flash can report ready on exactly the byte that uses up the poll limit. The bench provokes this by setting its flash model's busy-byte count to N-1 and to N for the same limit N. A limit of 0 is also tried, with zero and with one busy byte. It judges the result from the `err` level during the `done` pulse and from the number of status bytes it counts in the second chip-select frame. In the N-1 case that is N bytes with no error. In the N case it is N bytes with an error.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    localparam int PAGE_W = 11;

    typedef enum logic [2:0] {
        OP_PROG_ERASE = 3'd0,
        OP_PROG_KEEP  = 3'd1,
        OP_PAGE_ERASE = 3'd2,
        OP_BLK_ERASE  = 3'd3,
        OP_SEC_ERASE  = 3'd4,
        OP_CHIP_ERASE = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_POLL_OP,
        S_POLL_RD,
        S_DONE
    } state_e;

    localparam logic [7:0] OPC_PRG_E_B1  = 8'h83;
    localparam logic [7:0] OPC_PRG_E_B2  = 8'h86;
    localparam logic [7:0] OPC_PRG_K_B1  = 8'h88;
    localparam logic [7:0] OPC_PRG_K_B2  = 8'h89;
    localparam logic [7:0] OPC_PG_ERASE  = 8'h81;
    localparam logic [7:0] OPC_BLK_ERASE = 8'h50;
    localparam logic [7:0] OPC_SEC_ERASE = 8'h7C;
    localparam logic [7:0] OPC_STATUS    = 8'h57;
    localparam logic [31:0] CHIP_ERASE_SEQ = 32'hC794_809A;

endpackage

// File: rtl/flseq_frame.sv
module flseq_frame
    import flseq_pkg::*;
(
    input  logic [2:0]        op,
    input  logic              buf_sel,
    input  logic [PAGE_W-1:0] page,
    output logic [3:0][7:0]   frame,
    output logic              legal
);

    logic [23:0] addr_page;
    logic [23:0] addr_blk;
    logic [23:0] addr_sec;

    always_comb begin
        addr_page = {4'b0, page, 9'b0};
        addr_blk  = {4'b0, page[10:3], 12'b0};
        addr_sec  = {4'b0, page[10:8], 17'b0};
    end

    always_comb begin
        legal = 1'b1;
        frame = '0;
        unique case (op)
            OP_PROG_ERASE: frame = {buf_sel ? OPC_PRG_E_B2 : OPC_PRG_E_B1, addr_page};
            OP_PROG_KEEP:  frame = {buf_sel ? OPC_PRG_K_B2 : OPC_PRG_K_B1, addr_page};
            OP_PAGE_ERASE: frame = {OPC_PG_ERASE, addr_page};
            OP_BLK_ERASE:  frame = {OPC_BLK_ERASE, addr_blk};
            OP_SEC_ERASE:  frame = {OPC_SEC_ERASE, addr_sec};
            OP_CHIP_ERASE: frame = CHIP_ERASE_SEQ;
            default:       legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/flseq_byte_io.sv
module flseq_byte_io #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       active,
    output logic       done,
    output logic       rx_msb
);

    localparam int DIV_W = $clog2(HALF) + 1;

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sck    <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                tx_sh  <= tx;
                div_q  <= '0;
                bit_q  <= '0;
                sck    <= 1'b0;
            end else if (active) begin
                if (div_q == DIV_W'(HALF - 1)) begin
                    div_q <= '0;
                    if (!sck) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck   <= 1'b0;
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    always_comb begin
        mosi   = tx_sh[7];
        rx_msb = rx_sh[7];
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flseq_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int GAP_CLKS = 2,
    parameter int LIMIT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic               req_buf,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic [LIMIT_W-1:0] poll_limit,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);

    localparam int GAP_W = $clog2(GAP_CLKS) + 1;
    localparam logic [LIMIT_W-1:0] ONE = LIMIT_W'(1);

    state_e             st_q, st_nx;
    logic [3:0][7:0]    frm_d, frm_q;
    logic               legal;
    logic [1:0]         idx_q;
    logic [GAP_W-1:0]   gap_q;
    logic [LIMIT_W-1:0] pcnt_q, lim_q;
    logic               err_q;
    logic               cs_n_q;

    logic               eng_start, eng_active, eng_done, eng_rx_msb;
    logic [7:0]         eng_tx;
    logic               accept, gap_end, timeout;

    flseq_frame u_frame (
        .op      (req_op),
        .buf_sel (req_buf),
        .page    (req_page),
        .frame   (frm_d),
        .legal   (legal)
    );

    flseq_byte_io #(.HALF(SCK_HALF)) u_bytes (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .tx     (eng_tx),
        .miso   (spi_miso),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .active (eng_active),
        .done   (eng_done),
        .rx_msb (eng_rx_msb)
    );

    always_comb begin
        accept  = (st_q == S_IDLE) && req_valid && legal;
        gap_end = (gap_q == GAP_W'(GAP_CLKS - 1));
        timeout = (pcnt_q >= (lim_q - ONE));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE:    if (accept) st_nx = S_CMD;
            S_CMD:     if (eng_done && idx_q == 2'd3) st_nx = S_GAP;
            S_GAP:     if (gap_end) st_nx = S_POLL_OP;
            S_POLL_OP: if (eng_done) st_nx = S_POLL_RD;
            S_POLL_RD: if (eng_done && (eng_rx_msb || timeout)) st_nx = S_DONE;
            S_DONE:    st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // working registers and chip select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q  <= '0;
            idx_q  <= '0;
            gap_q  <= '0;
            pcnt_q <= '0;
            lim_q  <= ONE;
            err_q  <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= !(st_nx == S_CMD || st_nx == S_POLL_OP || st_nx == S_POLL_RD);
            if (accept) begin
                frm_q  <= frm_d;
                idx_q  <= '0;
                pcnt_q <= '0;
                err_q  <= 1'b0;
                lim_q  <= (poll_limit == '0) ? ONE : poll_limit;
            end
            if (st_q == S_CMD && eng_done) idx_q <= idx_q + 2'd1;
            if (st_q == S_GAP) gap_q <= gap_q + GAP_W'(1);
            else               gap_q <= '0;
            if (st_q == S_POLL_RD && eng_done && !eng_rx_msb) begin
                if (timeout) err_q <= 1'b1;
                else         pcnt_q <= pcnt_q + ONE;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (st_q != S_IDLE);
        done      = (st_q == S_DONE);
        err       = done && err_q;
        spi_cs_n  = cs_n_q;
        eng_start = 1'b0;
        eng_tx    = 8'h00;
        unique case (st_q)
            S_CMD: begin
                eng_start = !eng_active && !eng_done;
                eng_tx    = frm_q[3 - idx_q];
            end
            S_POLL_OP: begin
                eng_start = !eng_active && !eng_done;
                eng_tx    = OPC_STATUS;
            end
            S_POLL_RD: begin
                eng_start = !eng_active && !eng_done;
                eng_tx    = 8'h00;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       spi_sck,
    input logic       spi_cs_n
);

    p_idle_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    p_gap_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_only_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_busy_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_illegal_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op > 3'd5) |=> !busy);

    p_sck_low_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_buf = 1'b0;
    logic [10:0] req_page = '0;
    logic [15:0] poll_limit = '0;
    logic        busy, done, err;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_buf(req_buf), .req_page(req_page), .poll_limit(poll_limit),
        .busy(busy), .done(done), .err(err), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    // flash model state
    logic [7:0] fb [4][4];
    int   flen [4];
    int   nfr = 0;
    int   bitn = 0;
    logic [7:0] in_sh = '0;
    logic [7:0] st_sh = '0;
    bit   stat_mode = 0;
    int   cfg_busy = 0;
    int   busy_left = 0;
    int   hi_cnt = 0;
    int   last_gap = 0;
    int   done_cnt = 0;
    int   busy_seen = 0;

    always @(negedge spi_cs_n) begin
        bitn = 0;
        stat_mode = 0;
        if (nfr < 4) flen[nfr] = 0;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bitn++;
        if (bitn % 8 == 0) begin
            if (nfr < 4) begin
                if (flen[nfr] < 4) fb[nfr][flen[nfr]] = in_sh;
                flen[nfr]++;
            end
            if (bitn == 8 && in_sh == 8'h57) stat_mode = 1;
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n && stat_mode) begin
        if (bitn % 8 == 0) begin
            logic [7:0] v;
            v = 8'($urandom);
            if (busy_left > 0) begin
                v[7] = 1'b0;
                busy_left--;
            end else begin
                v[7] = 1'b1;
            end
            spi_miso <= v[7];
            st_sh = {v[6:0], 1'b0};
        end else begin
            spi_miso <= st_sh[7];
            st_sh = {st_sh[6:0], 1'b0};
        end
    end

    always @(posedge spi_cs_n) begin
        if (nfr < 4 && !stat_mode && flen[nfr] > 0) busy_left = cfg_busy;
        nfr++;
    end

    always @(negedge clk) begin
        if (spi_cs_n === 1'b1) hi_cnt++;
        else begin
            if (hi_cnt > 0) last_gap = hi_cnt;
            hi_cnt = 0;
        end
        if (done === 1'b1) done_cnt++;
        if (busy === 1'b1) busy_seen++;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input int op, input bit b, input logic [10:0] pg);
        case (op)
            0: return {b ? 8'h86 : 8'h83, 4'b0, pg, 9'b0};
            1: return {b ? 8'h89 : 8'h88, 4'b0, pg, 9'b0};
            2: return {8'h81, 4'b0, pg, 9'b0};
            3: return {8'h50, 4'b0, pg[10:3], 12'b0};
            4: return {8'h7C, 4'b0, pg[10:8], 17'b0};
            default: return 32'hC794_809A;
        endcase
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0, 1, 2: return "R2/R3";
            3, 4:    return "R2/R4";
            default: return "R5";
        endcase
    endfunction

    task automatic clear_log();
        nfr = 0;
        for (int i = 0; i < 4; i++) flen[i] = 0;
        done_cnt = 0;
        busy_seen = 0;
        last_gap = 0;
    endtask

    task automatic run_op(input int op, input bit b, input int pg, input int lim,
                          input int nbusy, input bit mid);
        int t;
        int l_eff;
        int e_reads;
        bit e_err;
        bit got_err;
        logic [31:0] ef;
        logic [31:0] af;
        @(negedge clk);
        clear_log();
        cfg_busy = nbusy;
        req_op = 3'(op);
        req_buf = b;
        req_page = 11'(pg);
        poll_limit = 16'(lim);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R9 busy after accept", longint'(busy), 1);
        if (mid) begin
            repeat (40) @(negedge clk);
            req_op = 3'd5;
            req_page = ~req_page;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (done !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(t < 20000, "R7 done reached", t, 0);
        l_eff = (lim == 0) ? 1 : lim;
        e_err = (nbusy >= l_eff);
        e_reads = e_err ? l_eff : nbusy + 1;
        got_err = err;
        check(got_err == e_err, e_err ? "R8 err on timeout" : "R7 err low when ready",
              longint'(got_err), longint'(e_err));
        repeat (4) @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && done_cnt == 1, "R7 single done pulse",
              done_cnt, 1);
        check(nfr == 2, mid ? "R9 request while busy ignored" : "R6 two frames", nfr, 2);
        check(flen[0] == 4, "R2 command length", flen[0], 4);
        ef = exp_frame(op, b, 11'(pg));
        af = {fb[0][0], fb[0][1], fb[0][2], fb[0][3]};
        check(af == ef, {op_tag(op), "/R11 command bytes"}, af, ef);
        check(fb[1][0] == 8'h57, "R7 status opcode", fb[1][0], 8'h57);
        check(flen[1] == 1 + e_reads, e_err ? "R8 status byte count" : "R7 status byte count",
              flen[1], 1 + e_reads);
        check(last_gap >= 2, "R6 chip select gap", last_gap, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 link idle",
              longint'({spi_cs_n, spi_sck}), 2);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 flags clear",
              longint'({busy, done, err}), 0);

        // R10 illegal codes
        clear_log();
        for (int c = 6; c < 8; c++) begin
            req_op = 3'(c);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (100) @(negedge clk);
        end
        check(nfr == 0 && busy_seen == 0 && done_cnt == 0, "R10 illegal op ignored",
              nfr + busy_seen + done_cnt, 0);

        // directed corners
        run_op(0, 1'b0, 11'h7FF, 3, 2, 1'b0);  // ready on last allowed byte
        run_op(0, 1'b1, 11'h555, 3, 3, 1'b0);  // limit used up
        run_op(1, 1'b0, 11'h001, 0, 0, 1'b0);  // zero limit, immediately ready
        run_op(1, 1'b1, 11'h2AA, 0, 1, 1'b0);  // zero limit counts as one
        run_op(2, 1'b0, 11'h400, 5, 0, 1'b0);
        run_op(3, 1'b1, 11'h7FF, 4, 1, 1'b0);  // R4 low page bits dropped
        run_op(4, 1'b0, 11'h6FF, 4, 2, 1'b0);  // R4 sector bits only
        run_op(5, 1'b1, 11'h123, 6, 4, 1'b0);  // R5 fixed sequence
        run_op(2, 1'b0, 11'h0F0, 8, 6, 1'b1);  // R9 mid-operation request

        for (int i = 0; i < 30; i++) begin
            run_op($urandom_range(0, 5), 1'($urandom), $urandom_range(0, 2047),
                   $urandom_range(0, 8), $urandom_range(0, 10), 1'($urandom_range(0, 3) == 0));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule